// File: doc/BRIEF.md
# Least-Recently-Scheduled Thread Issue Selector

This block sits at the thread select point of a barrel-style multithreaded pipeline. In every cycle it decides which hardware thread may send one instruction down the shared pipeline. Each thread reports four things: whether it holds a ready instruction, whether that instruction is a load, and whether the thread is held back by a cache miss, by a pending trap or interrupt, or by a resource conflict. Any eligible thread can be chosen in any cycle. A change of thread costs no cycle and does not flush the pipeline.

Among the eligible threads the block grants the one that has gone longest without a grant. It keeps an age list of thread numbers. A granted thread moves to the newest position, and the list stays as it is in a cycle with no grant. When a load is granted, that thread is kept out for the next two cycles so that its result can be forwarded. Other threads may issue in those cycles. The decision depends combinationally on the inputs and the registered state of the current cycle. The grant is presented as a one-hot vector together with a binary thread index.

Top module: `thread_sel_sched`

## Requirements
- R1: After reset the age order is thread 0 oldest up to thread 3 newest, and no thread is under a load hold. With all threads ready, the first grant goes to thread 0.
- R2: `grant` has at most one bit set, where bit i means thread i. When a bit is set, `grant_idx` equals its position.
- R3: A thread whose bit in `thr_valid` is 0 is never granted.
- R4: A thread whose bit is 1 in any of `thr_miss`, `thr_trap` or `thr_conflict` is never granted in that cycle.
- R5: Among the eligible threads, the one granted least recently wins. The granted thread becomes the most recent in the order.
- R6: In a cycle with no grant the age order is unchanged.
- R7: When thread i is granted with its `thr_load` bit at 1, thread i is not granted in either of the next two cycles. Other eligible threads are still granted in those cycles.
- R8: In the third cycle after its load grant, the thread is eligible again.
- R9: When no thread is eligible, `grant` is all zeros, `grant_idx` is 0 and `idle` is 1. Otherwise `idle` is 0.
- R10: A grant without a load puts no hold on the thread. It may be granted again in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_valid | input | N_THR | Per thread: a ready instruction is present |
| thr_load | input | N_THR | Per thread: the ready instruction is a load |
| thr_miss | input | N_THR | Per thread: stalled by a cache miss |
| thr_trap | input | N_THR | Per thread: a trap or interrupt is pending |
| thr_conflict | input | N_THR | Per thread: a resource conflict blocks issue |
| grant | output | N_THR | One-hot issue grant, bit i for thread i |
| grant_idx | output | $clog2(N_THR) | Number of the granted thread, 0 when idle |
| idle | output | 1 | No thread is eligible this cycle |

## Verification
The bench builds the block with its default values: four threads and a load hold of two cycles. With four threads the whole age list can be walked. This covers the same thread winning back to back, a thread that stays oldest while it is blocked, and two overlapping load holds whose releases fall in different cycles. A hold of two cycles lets the bench see the blocked cycles and the release cycle one by one. The bench also places a reset during an active hold, which shows that the hold is cleared.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
   // Width of a thread number for a given thread count
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
   // Width of a hold counter for a given hold length
   function automatic int hold_w(input int h);
      return (h > 0) ? $clog2(h + 1) : 1;
   endfunction
endpackage

// File: rtl/tsel_hold.sv
module tsel_hold #(
   parameter int HOLD_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic blocked
);
   localparam int CW = tsel_pkg::hold_w(HOLD_CYC);

   generate
      if (HOLD_CYC == 0) begin : g_nohold
         assign blocked = 1'b0;
      end else begin : g_cnt
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (arm)
               cnt_q <= CW'(HOLD_CYC);
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign blocked = (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/tsel_age.sv
module tsel_age #(
   parameter int N_THR = 4
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [N_THR-1:0]                     elig,
   output logic                                 found,
   output logic [tsel_pkg::idx_w(N_THR)-1:0]    pick
);
   localparam int IW = tsel_pkg::idx_w(N_THR);

   logic [IW-1:0] ord_q [N_THR];
   logic [IW-1:0] ord_d [N_THR];
   logic [IW-1:0] pos;

   // Scan from the oldest slot and stop at the first eligible thread
   always_comb begin
      found = 1'b0;
      pos   = '0;
      for (int p = 0; p < N_THR; p++) begin
         if (!found && elig[ord_q[p]]) begin
            found = 1'b1;
            pos   = IW'(p);
         end
      end
   end

   assign pick = found ? ord_q[pos] : '0;

   // Move the winner to the newest slot and close the gap behind it
   always_comb begin
      for (int p = 0; p < N_THR; p++) ord_d[p] = ord_q[p];
      if (found) begin
         for (int p = 0; p < N_THR - 1; p++) begin
            if (IW'(p) >= pos) ord_d[p] = ord_q[p + 1];
         end
         ord_d[N_THR-1] = ord_q[pos];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < N_THR; p++) ord_q[p] <= IW'(p);
      end else begin
         for (int p = 0; p < N_THR; p++) ord_q[p] <= ord_d[p];
      end
   end
endmodule

// File: rtl/thread_sel_sched.sv
module thread_sel_sched #(
   parameter int N_THR    = 4,
   parameter int HOLD_CYC = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [N_THR-1:0]                   thr_valid,
   input  logic [N_THR-1:0]                   thr_load,
   input  logic [N_THR-1:0]                   thr_miss,
   input  logic [N_THR-1:0]                   thr_trap,
   input  logic [N_THR-1:0]                   thr_conflict,
   output logic [N_THR-1:0]                   grant,
   output logic [tsel_pkg::idx_w(N_THR)-1:0]  grant_idx,
   output logic                               idle
);
   localparam int IW = tsel_pkg::idx_w(N_THR);

   generate
      if (N_THR < 2) begin : g_bad_n
         $error("thread_sel_sched: N_THR must be at least 2");
      end
      if (HOLD_CYC < 0) begin : g_bad_h
         $error("thread_sel_sched: HOLD_CYC must not be negative");
      end
   endgenerate

   logic [N_THR-1:0] held;
   logic [N_THR-1:0] elig;
   logic             found;
   logic [IW-1:0]    pick;

   genvar t;
   generate
      for (t = 0; t < N_THR; t++) begin : g_thr
         tsel_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm     (grant[t] & thr_load[t]),
            .blocked (held[t])
         );
      end
   endgenerate

   assign elig = thr_valid & ~thr_miss & ~thr_trap & ~thr_conflict & ~held;

   tsel_age #(.N_THR(N_THR)) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .elig  (elig),
      .found (found),
      .pick  (pick)
   );

   always_comb begin
      grant = '0;
      if (found) grant[pick] = 1'b1;
   end

   assign grant_idx = pick;
   assign idle      = ~found;
endmodule

// File: rtl/tsel_chk.sv
module tsel_chk #(
   parameter int N_THR    = 4,
   parameter int HOLD_CYC = 2
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic [N_THR-1:0]                   thr_valid,
   input logic [N_THR-1:0]                   thr_load,
   input logic [N_THR-1:0]                   thr_miss,
   input logic [N_THR-1:0]                   thr_trap,
   input logic [N_THR-1:0]                   thr_conflict,
   input logic [N_THR-1:0]                   grant,
   input logic [tsel_pkg::idx_w(N_THR)-1:0]  grant_idx,
   input logic                               idle
);
   localparam int CW = tsel_pkg::hold_w(HOLD_CYC);

   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r2_index: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> grant[grant_idx]);

   a_r3_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~thr_valid) == '0);

   a_r4_no_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & (thr_miss | thr_trap | thr_conflict)) == '0);

   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (grant == '0 && grant_idx == '0));

   a_r9_busy_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> (grant != '0));

   genvar t;
   generate
      if (HOLD_CYC > 0) begin : g_hold_chk
         for (t = 0; t < N_THR; t++) begin : g_thr
            logic [CW-1:0] win_q;
            always_ff @(posedge clk) begin
               if (!rst_n)
                  win_q <= '0;
               else if (grant[t] && thr_load[t])
                  win_q <= CW'(HOLD_CYC);
               else if (win_q != '0)
                  win_q <= win_q - 1'b1;
            end
            // R7: no grant to a thread inside its load window
            a_r7_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
               (win_q != '0) |-> !grant[t]);
         end
      end
   endgenerate
endmodule

bind thread_sel_sched tsel_chk #(.N_THR(N_THR), .HOLD_CYC(HOLD_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .thr_valid    (thr_valid),
   .thr_load     (thr_load),
   .thr_miss     (thr_miss),
   .thr_trap     (thr_trap),
   .thr_conflict (thr_conflict),
   .grant        (grant),
   .grant_idx    (grant_idx),
   .idle         (idle)
);

// File: tb/tb_thread_sel_sched.sv
module tb_thread_sel_sched;
   localparam int N = 4;
   localparam int NROW = 19;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] thr_valid = '0, thr_load = '0, thr_miss = '0, thr_trap = '0, thr_conflict = '0;
   logic [N-1:0] grant;
   logic [1:0]   grant_idx;
   logic         idle;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   thread_sel_sched #(.N_THR(N), .HOLD_CYC(2)) dut (
      .clk(clk), .rst_n(rst_n),
      .thr_valid(thr_valid), .thr_load(thr_load), .thr_miss(thr_miss),
      .thr_trap(thr_trap), .thr_conflict(thr_conflict),
      .grant(grant), .grant_idx(grant_idx), .idle(idle)
   );

   // Row: {valid, load, miss, trap, conflict, expected grant, expected idle}
   localparam logic [24:0] TBL [NROW] = '{
      {4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b0}, // 0  R1 t0 first
      {4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b0}, // 1  R5
      {4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b0}, // 2  R3
      {4'b1111, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b1000, 1'b0}, // 3  R4 miss
      {4'b1111, 4'b0000, 4'b0000, 4'b0100, 4'b0010, 4'b0001, 1'b0}, // 4  R4 trap/conflict
      {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1}, // 5  R9
      {4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 1'b0}, // 6  R6
      {4'b1111, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b0}, // 7  R7 load t1
      {4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1}, // 8  R7 held
      {4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1000, 1'b0}, // 9  R7 other issues
      {4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b0}, // 10 R8 release
      {4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b0}, // 11 R10
      {4'b0010, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b0}, // 12 R7 load t1
      {4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b0}, // 13 R7 load t0
      {4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 1'b0}, // 14 R7 two held
      {4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1000, 1'b0}, // 15 R8 t0 still held
      {4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b0}, // 16 R8 t1 back
      {4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b0}, // 17 R8 t0 back
      {4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1}  // 18 R9 all missed
   };

   function automatic string row_tag(input int r);
      case (r)
         0:               return "R1";
         1:               return "R5";
         2:               return "R3";
         3, 4:            return "R4";
         5, 18:           return "R9";
         6:               return "R6";
         10, 15, 16, 17:  return "R8";
         11:              return "R10";
         default:         return "R7";
      endcase
   endfunction

   task automatic check(input string tag, input logic [N-1:0] eg, input logic ei);
      logic [1:0] eidx;
      eidx = '0;
      for (int i = 0; i < N; i++) if (eg[i]) eidx = 2'(i);
      total++;
      if (grant !== eg || idle !== ei || grant_idx !== eidx) begin
         bad++;
         $display("FAIL %s: grant=%b idx=%0d idle=%b expected grant=%b idx=%0d idle=%b",
                  tag, grant, grant_idx, idle, eg, eidx, ei);
      end
   endtask

   task automatic drive(input logic [N-1:0] v, input logic [N-1:0] l,
                        input logic [N-1:0] m, input logic [N-1:0] tr, input logic [N-1:0] c);
      thr_valid = v; thr_load = l; thr_miss = m; thr_trap = tr; thr_conflict = c;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 also covers the reset state with nothing ready
      #1 check("R9 reset quiet", 4'b0000, 1'b1);
      rst_n = 1'b1;
      for (int r = 0; r < NROW; r++) begin
         @(negedge clk);
         drive(TBL[r][24:21], TBL[r][20:17], TBL[r][16:13], TBL[r][12:9], TBL[r][8:5]);
         #1 check(row_tag(r), TBL[r][4:1], TBL[r][0]);
      end
      // R1: reset while a hold is active clears it and restores the order
      @(negedge clk);
      drive(4'b0001, 4'b0001, 4'b0000, 4'b0000, 4'b0000);
      #1 check("R7 load t0 pre-reset", 4'b0001, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      drive(4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;
      drive(4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
      #1 check("R1 hold cleared", 4'b0001, 1'b0);
      @(negedge clk);
      drive(4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
      #1 check("R1 order after reset", 4'b0010, 1'b0);
      @(negedge clk);
      drive(4'b1001, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
      #1 check("R5 oldest of t0/t3", 4'b1000, 1'b0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule